// File: doc/BRIEF.md
# Receiver Master-Clock Ratio Controller

This block is the control path of a digital audio receiver's clock unit. It chooses whether the system master clock comes from the free-running crystal or from the clock that the PLL recovers from the incoming stream. When the PLL clock is in use, the block also picks its frequency as a multiple of the sample rate: 512fs, 256fs or 128fs. The analog PLL, the sample-rate measurement and the glitch-free clock switch sit outside the block; they connect through the lock flag, the band code, the source select and the ratio code.

The ratio comes from one of two modes. In automatic mode it follows the measured sample-rate band, adjusted by two per-band divider bits. In fixed mode it comes from a 2-bit code and ignores the sample rate. Configuration written while the PLL is locked is held back and takes effect at the next lock. The one exception is a fixed-ratio change in fixed mode with update permission set, which applies at once and leaves the mute request alone. A sample rate above the programmed limit is handled as loss of lock. A mute request covers every lock transition and stays asserted for a programmable number of cycles after lock returns.

Top module: `mclk_ratio_ctrl`

## Requirements
- R1: `clk_sel_o` is 1 (PLL clock) one clock edge after the lock is valid. Lock is valid when `lock_i`=1, `pll_stop_i`=0 and the band is within the limit. In every other case `clk_sel_o` is 0 (crystal) one edge later.
- R2: In automatic mode (active mode bit 0), band `band_i` is decoded as 00 = 32-48 kHz, 01 = 64-96 kHz, 10 = 128-192 kHz and 11 = above. The divider bits set the ratio as follows:
  - band 00 gives 256fs if divider bit 0 is 1, otherwise 512fs.
  - band 01 gives 512fs if divider bit 1 is 1, otherwise 256fs.
  - bands 10 and 11 give 128fs.
- R3: In fixed mode (active mode bit 1), the fixed code sets the ratio regardless of band: 00 gives 256fs, 01 gives 512fs, 10 gives 128fs and 11 gives 256fs.
- R4: While the lock is valid, writes to `mode_i`, `div_i` and `fix_i` do not change `ratio_o`. The active configuration copies these inputs only while unlocked, so a change takes effect at the next lock.
- R5: While locked, with the active mode fixed and `upd_perm_i`=1, a new `fix_i` value reaches `ratio_o` two edges later.
- R6: A ratio change made under R5 leaves `mute_o` deasserted.
- R7: `lim_i` is the highest accepted band code. If `band_i` > `lim_i`, the block behaves as unlocked: it selects the crystal, raises mute and stops updating the ratio.
- R8: `pll_en_o` is 0 one edge after `pll_stop_i`=1, and 1 one edge after `pll_stop_i`=0. While the stop is set, the crystal is selected.
- R9: `mute_o` is 1 while the lock is invalid. After the lock becomes valid, `mute_o` stays 1 for HOLD_CYC+1 edges and then clears.
- R10: `ratio_o` uses only 00 = 256fs, 01 = 512fs and 10 = 128fs, and holds its value while the lock is invalid. After reset: `ratio_o`=01, `clk_sel_o`=0, `pll_en_o`=0, `mute_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | PLL lock flag |
| band_i | input | 2 | Measured sample-rate band code |
| lim_i | input | 2 | Highest accepted band code |
| pll_stop_i | input | 1 | Stop PLL, force crystal |
| mode_i | input | 1 | 0 automatic band mode, 1 fixed mode |
| div_i | input | 2 | Per-band divider bits for automatic mode |
| fix_i | input | 2 | Fixed-mode ratio code |
| upd_perm_i | input | 1 | Permit fixed-ratio update while locked |
| clk_sel_o | output | 1 | 1 PLL clock, 0 crystal |
| ratio_o | output | 2 | PLL output ratio code |
| pll_en_o | output | 1 | PLL enable |
| mute_o | output | 1 | Mute request |

## Verification
The assertions check the following on every cycle:
- the crystal fallback for loss of lock, the over-limit condition and the stop;
- the PLL enable response;
- the freezing of the active configuration while locked, unless a permitted fixed update applies;
- the legal ratio codes, and that the ratio holds while unlocked;
- that mute is raised while unlocked and at relock, and is not raised again during a steady lock.

Only the bench scenarios show the rest:
- the exact band and divider mapping;
- that a held-back write takes effect at the next lock;
- the exact length of the mute hold.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;
  localparam int unsigned RATIO_W = 2;
  localparam int unsigned BAND_W  = 2;

  typedef enum logic [RATIO_W-1:0] {
    RATIO_256 = 2'b00,
    RATIO_512 = 2'b01,
    RATIO_128 = 2'b10
  } ratio_e;

  localparam logic [BAND_W-1:0] BAND_LOW  = 2'b00;
  localparam logic [BAND_W-1:0] BAND_MID  = 2'b01;

  typedef struct packed {
    logic              fixed;
    logic [1:0]        div;
    logic [RATIO_W-1:0] fix;
  } cfg_t;
endpackage

// File: rtl/mclk_cfg_latch.sv
module mclk_cfg_latch
  import mclk_ratio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_ok_i,
  input  cfg_t cfg_i,
  input  logic upd_perm_i,
  output cfg_t act_o
);
  cfg_t act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (!lock_ok_i) begin
      act_q <= cfg_i;
    end else if (act_q.fixed && upd_perm_i) begin
      act_q.fix <= cfg_i.fix;
    end
  end

  assign act_o = act_q;

  assert_cfg_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_ok_i |=> ($stable(act_q.fixed) && $stable(act_q.div)));

  assert_fix_needs_perm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_ok_i && !(act_q.fixed && upd_perm_i)) |=> $stable(act_q.fix));
endmodule

// File: rtl/mclk_ratio_sel.sv
module mclk_ratio_sel
  import mclk_ratio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lock_ok_i,
  input  cfg_t               act_i,
  input  logic [BAND_W-1:0]  band_i,
  output logic [RATIO_W-1:0] ratio_o
);
  ratio_e ratio_nxt;
  ratio_e ratio_q;

  always_comb begin
    if (act_i.fixed) begin
      unique case (act_i.fix)
        2'b01:   ratio_nxt = RATIO_512;
        2'b10:   ratio_nxt = RATIO_128;
        default: ratio_nxt = RATIO_256;
      endcase
    end else begin
      unique case (band_i)
        BAND_LOW: ratio_nxt = act_i.div[0] ? RATIO_256 : RATIO_512;
        BAND_MID: ratio_nxt = act_i.div[1] ? RATIO_512 : RATIO_256;
        default:  ratio_nxt = RATIO_128;
      endcase
    end
  end

  // ratio only advances while lock is valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ratio_q <= RATIO_512;
    else if (lock_ok_i) ratio_q <= ratio_nxt;
  end

  assign ratio_o = ratio_q;

  assert_ratio_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_o != 2'b11);

  assert_ratio_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_ok_i |=> $stable(ratio_o));
endmodule

// File: rtl/mclk_mute_timer.sv
module mclk_mute_timer #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_ok_i,
  output logic mute_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(HOLD_CYC);

  logic             lock_q;
  logic             mute_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      mute_q <= 1'b1;
      cnt_q  <= CNT_INIT;
    end else begin
      lock_q <= lock_ok_i;
      if (!lock_ok_i || !lock_q) begin
        mute_q <= 1'b1;
        cnt_q  <= CNT_INIT;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
      end else begin
        mute_q <= 1'b0;
      end
    end
  end

  assign mute_o = mute_q;

  assert_mute_unlocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_ok_i |=> mute_o);

  assert_mute_relock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_ok_i && !lock_q) |=> mute_o);

  assert_mute_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_o && lock_ok_i && lock_q) |=> !mute_o);
endmodule

// File: rtl/mclk_ratio_ctrl.sv
module mclk_ratio_ctrl
  import mclk_ratio_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_i,
  input  logic [1:0] band_i,
  input  logic [1:0] lim_i,
  input  logic       pll_stop_i,
  input  logic       mode_i,
  input  logic [1:0] div_i,
  input  logic [1:0] fix_i,
  input  logic       upd_perm_i,
  output logic       clk_sel_o,
  output logic [1:0] ratio_o,
  output logic       pll_en_o,
  output logic       mute_o
);
  logic over_lim;
  logic lock_ok;
  cfg_t cfg_in;
  cfg_t cfg_act;
  logic clk_sel_q;
  logic pll_en_q;

  assign over_lim = band_i > lim_i;
  assign lock_ok  = lock_i && !pll_stop_i && !over_lim;
  assign cfg_in   = '{fixed: mode_i, div: div_i, fix: fix_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q <= 1'b0;
      pll_en_q  <= 1'b0;
    end else begin
      clk_sel_q <= lock_ok;
      pll_en_q  <= !pll_stop_i;
    end
  end

  assign clk_sel_o = clk_sel_q;
  assign pll_en_o  = pll_en_q;

  mclk_cfg_latch u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_ok_i  (lock_ok),
    .cfg_i      (cfg_in),
    .upd_perm_i (upd_perm_i),
    .act_o      (cfg_act)
  );

  mclk_ratio_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_ok_i (lock_ok),
    .act_i     (cfg_act),
    .band_i    (band_i),
    .ratio_o   (ratio_o)
  );

  mclk_mute_timer #(.HOLD_CYC(HOLD_CYC)) u_mute (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_ok_i (lock_ok),
    .mute_o    (mute_o)
  );

  assert_xtal_on_unlock_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !clk_sel_o);

  assert_xtal_over_lim_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_i > lim_i) |=> (!clk_sel_o && mute_o));

  assert_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_stop_i |=> (!pll_en_o && !clk_sel_o));

  assert_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_stop_i |=> pll_en_o);
endmodule

// File: tb/mclk_ratio_ctrl_bench.sv
module mclk_ratio_ctrl_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HOLD = 5;
  localparam int unsigned NVEC = 10;

  // {mode, div[1:0], fix[1:0], band[1:0], expected ratio[1:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0_00_00_00_01,  // R2 low band, 512
    9'b0_01_00_00_00,  // R2 low band, div0 -> 256
    9'b0_00_00_01_00,  // R2 mid band, 256
    9'b0_10_00_01_01,  // R2 mid band, div1 -> 512
    9'b0_11_00_10_10,  // R2 high band, 128
    9'b0_00_00_11_10,  // R2 above high, 128
    9'b1_00_00_00_00,  // R3 fix 00 -> 256
    9'b1_11_01_10_01,  // R3 fix 01 -> 512
    9'b1_00_10_01_10,  // R3 fix 10 -> 128
    9'b1_01_11_00_00   // R3 fix 11 -> 256
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock = 1'b0;
  logic [1:0] band = 2'b00;
  logic [1:0] lim = 2'b11;
  logic       stop = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] div = 2'b00;
  logic [1:0] fix = 2'b00;
  logic       perm = 1'b0;
  logic       clk_sel;
  logic [1:0] ratio;
  logic       pll_en;
  logic       mute;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclk_ratio_ctrl #(.HOLD_CYC(HOLD)) u_mclk_ratio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .band_i(band), .lim_i(lim),
    .pll_stop_i(stop), .mode_i(mode), .div_i(div), .fix_i(fix),
    .upd_perm_i(perm), .clk_sel_o(clk_sel), .ratio_o(ratio),
    .pll_en_o(pll_en), .mute_o(mute)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    step(2);
    // R10 reset state
    chk("R10 reset ratio", 32'(ratio), 32'h1);
    chk("R10 reset clk_sel", 32'(clk_sel), 32'h0);
    chk("R10 reset pll_en", 32'(pll_en), 32'h0);
    chk("R10 reset mute", 32'(mute), 32'h1);
    rst_n = 1'b1;
    step(2);
    chk("R8 pll_en running", 32'(pll_en), 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      lock = 1'b0;
      {mode, div, fix, band} = VEC[i][8:2];
      step(3);
      lock = 1'b1;
      step(3);
      chk($sformatf("R2/R3 vec %0d ratio", i), 32'(ratio), 32'(VEC[i][1:0]));
      chk($sformatf("R1 vec %0d clk_sel", i), 32'(clk_sel), 32'h1);
    end

    // R9 exact mute hold
    lock = 1'b0; mode = 1'b0; div = 2'b00; band = 2'b00;
    step(3);
    chk("R9 mute while unlocked", 32'(mute), 32'h1);
    chk("R1 crystal while unlocked", 32'(clk_sel), 32'h0);
    lock = 1'b1;
    step(HOLD + 1);
    chk("R9 mute still held", 32'(mute), 32'h1);
    step(1);
    chk("R9 mute released", 32'(mute), 32'h0);
    chk("R2 low band relock ratio", 32'(ratio), 32'h1);

    // R4 writes while locked are held back
    mode = 1'b1; fix = 2'b10; div = 2'b01;
    step(4);
    chk("R4 ratio unchanged while locked", 32'(ratio), 32'h1);
    lock = 1'b0;
    step(3);
    chk("R10 ratio held while unlocked", 32'(ratio), 32'h1);
    lock = 1'b1;
    step(3);
    chk("R4 deferred write applied", 32'(ratio), 32'h2);

    // R5 / R6 permitted update while locked
    step(HOLD + 2);
    chk("R6 mute low before update", 32'(mute), 32'h0);
    perm = 1'b1; fix = 2'b00;
    begin
      int mute_seen = 0;
      for (int k = 0; k < 4; k++) begin
        step(1);
        if (mute) mute_seen++;
      end
      chk("R6 no mute on permitted update", 32'(mute_seen), 32'h0);
    end
    chk("R5 permitted ratio applied", 32'(ratio), 32'h0);
    perm = 1'b0; fix = 2'b01;
    step(3);
    chk("R4 no update without permission", 32'(ratio), 32'h0);

    // R7 over-limit acts as unlock
    lim = 2'b01; band = 2'b10;
    step(1);
    chk("R7 crystal on over-limit", 32'(clk_sel), 32'h0);
    chk("R7 mute on over-limit", 32'(mute), 32'h1);
    step(3);
    chk("R7 ratio frozen on over-limit", 32'(ratio), 32'h0);
    band = 2'b01;
    step(3);
    chk("R7 within limit relocks", 32'(clk_sel), 32'h1);
    chk("R7 latched write applied after relock", 32'(ratio), 32'h1);

    // R8 pll stop
    stop = 1'b1;
    step(1);
    chk("R8 pll_en off", 32'(pll_en), 32'h0);
    chk("R8 crystal forced", 32'(clk_sel), 32'h0);
    stop = 1'b0;
    step(2);
    chk("R8 pll_en back on", 32'(pll_en), 32'h1);
    chk("R8 PLL source again", 32'(clk_sel), 32'h1);

    summary();
  end
endmodule